// File: doc/BRIEF.md
# Sequential Non-Restoring Single-Precision Divider

This block divides one single-precision operand by another. Each operand arrives as three separate fields: a sign bit, an 8-bit biased exponent, and a 24-bit mantissa with the leading one written out. The result sign and the base exponent are formed as soon as the operation starts. The mantissa quotient comes from a non-restoring shift/add-subtract loop on 32-bit registers, which produces one quotient bit per clock.

Before the loop, the dividend mantissa is moved right by a fixed pre-shift. The bits shifted out feed the low end of the partial remainder, one per iteration, and zeros follow them. The exponent is raised by the same amount. After the last iteration, a leading-one detector brings the quotient back to the implicit-bit position. The detector corrects the exponent by the shift amount and drops the bits below the mantissa without rounding.

A host pulses `start_i` with the operand fields valid. It then waits for the one-cycle `done_o` pulse, which comes a fixed number of cycles later. At that point it reads a packed single-precision word. Rounding, special values, divide-by-zero signalling and exponent range checks are not part of this block.

Top module: `fpdiv_nr`

## Requirements
- R1: The result sign (bit 31 of `result_o`) is the XOR of `sign_a_i` and `sign_b_i`.
- R2: The result exponent (bits 30:23) is `exp_a_i - exp_b_i + 127` when `man_a_i >= man_b_i`, and one less otherwise. It is computed modulo 256, with no overflow or underflow handling.
- R3: The result fraction (bits 22:0) is the low 23 bits of `floor(man_a_i * 2^23 / man_b_i)` when `man_a_i >= man_b_i`, or of `floor(man_a_i * 2^24 / man_b_i)` otherwise. This is a truncated quotient whose hidden bit is the leading one. Operand mantissas carry the leading one in bit 23.
- R4: The quotient is built by 32 non-restoring iterations, one per clock, after a pre-shift of 8 places. During the loop the partial remainder stays within [-divisor, divisor).
- R5: `done_o` is high for exactly one cycle. That cycle is 33 rising edges after the edge that accepted `start_i`.
- R6: `result_o` changes only in the cycle that `done_o` rises. It then holds its value until the next `done_o`.
- R7: A `start_i` pulse that arrives while an operation is running is ignored. The operands of the running operation are kept, and no extra `done_o` is produced.
- R8: A zero divisor mantissa gives `result_o = 32'h00000000`, with `done_o` on the normal schedule.
- R9: A zero dividend mantissa gives `result_o = 32'h00000000`.
- R10: While `rst_ni` is low, `done_o` and `result_o` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a division when idle |
| sign_a_i | input | 1 | Dividend sign |
| exp_a_i | input | 8 | Dividend biased exponent |
| man_a_i | input | 24 | Dividend mantissa, explicit leading one |
| sign_b_i | input | 1 | Divisor sign |
| exp_b_i | input | 8 | Divisor biased exponent |
| man_b_i | input | 24 | Divisor mantissa, explicit leading one |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Packed quotient: sign, exponent, fraction |

## Verification
The divider is driven with hand-picked quotients and with a run of pseudo-random operands, all compared against an exact integer-division model.
- Equal mantissas and powers of two give an exact leading one, so they separate the two exponent-correction paths.
- One third and a near-two over one ratio expose any error in the truncation or in the last quotient bit.
- The sample value 0x19FF0000 / 0x18010000 = 0x417D05F4 covers a quotient just below two.
- Mixed signs show the sign path working on its own, apart from the mantissa.
- Zero mantissas on either side, and a start pulse sent in the middle of a run, show that the schedule and the captured operands are unaffected.

// File: rtl/fpdiv_nr_pkg.sv
`timescale 1ns/1ps
package fpdiv_nr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_NORM = 2'd2
  } div_state_e;

  function automatic int exp_bias(input int exp_w);
    return (1 << (exp_w - 1)) - 1;
  endfunction
endpackage

// File: rtl/fpdiv_nr_se.sv
`timescale 1ns/1ps
module fpdiv_nr_se #(
  parameter int EXP_W    = 8,
  parameter int PRESHIFT = 8,
  localparam int EB_W    = EXP_W + 2
) (
  input  logic             sign_a_i,
  input  logic             sign_b_i,
  input  logic [EXP_W-1:0] exp_a_i,
  input  logic [EXP_W-1:0] exp_b_i,
  output logic             sign_o,
  output logic [EB_W-1:0]  exp_base_o
);
  import fpdiv_nr_pkg::*;

  localparam int OFFS = exp_bias(EXP_W) + PRESHIFT;

  assign sign_o     = sign_a_i ^ sign_b_i;
  // biased difference, plus the pre-shift that normalization takes back
  assign exp_base_o = EB_W'({2'b00, exp_a_i}) - EB_W'({2'b00, exp_b_i}) + EB_W'(OFFS);
endmodule

// File: rtl/fpdiv_nr_core.sv
`timescale 1ns/1ps
module fpdiv_nr_core #(
  parameter int MAN_W    = 24,
  parameter int Q_W      = 32,
  parameter int PRESHIFT = 8,
  localparam int EXT_W   = MAN_W + Q_W,
  localparam int CNT_W   = $clog2(Q_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [MAN_W-1:0] man_a_i,
  input  logic [MAN_W-1:0] man_b_i,
  output logic             last_o,
  output logic [Q_W-1:0]   quot_o
);
  logic [EXT_W-1:0] ext;
  logic [Q_W-1:0]   rem_q, strm_q, quot_q, div_q;
  logic [Q_W-1:0]   rem_sh, rem_nx;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  // pre-shift: high part seeds the remainder, shifted-out bits feed the stream
  assign ext = {man_a_i, {Q_W{1'b0}}} >> PRESHIFT;

  always_comb begin
    rem_sh = {rem_q[Q_W-2:0], strm_q[Q_W-1]};
    rem_nx = rem_q[Q_W-1] ? (rem_sh + div_q) : (rem_sh - div_q);
  end

  assign last_o = run_q && (cnt_q == CNT_W'(Q_W - 1));
  assign quot_o = quot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      strm_q <= '0;
      quot_q <= '0;
      div_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
    end else if (load_i) begin
      rem_q  <= Q_W'(ext[EXT_W-1 -: MAN_W]);
      strm_q <= ext[Q_W-1:0];
      quot_q <= '0;
      div_q  <= Q_W'(man_b_i);
      cnt_q  <= '0;
      run_q  <= 1'b1;
    end else if (run_q) begin
      rem_q  <= rem_nx;
      strm_q <= strm_q << 1;
      quot_q <= {quot_q[Q_W-2:0], ~rem_nx[Q_W-1]};
      cnt_q  <= cnt_q + 1'b1;
      if (last_o) run_q <= 1'b0;
    end
  end

  // R4
  rem_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && div_q[MAN_W-1]) |->
      ($signed(rem_q) < $signed(div_q)) && ($signed(rem_q) >= -$signed(div_q)));
endmodule

// File: rtl/fpdiv_nr_norm.sv
`timescale 1ns/1ps
module fpdiv_nr_norm #(
  parameter int MAN_W   = 24,
  parameter int EXP_W   = 8,
  parameter int Q_W     = 32,
  localparam int EB_W   = EXP_W + 2,
  localparam int LZ_W   = $clog2(Q_W + 1),
  localparam int WORD_W = 1 + EXP_W + MAN_W - 1
) (
  input  logic              sign_i,
  input  logic [EB_W-1:0]   exp_base_i,
  input  logic              zero_i,
  input  logic [Q_W-1:0]    quot_i,
  output logic [WORD_W-1:0] word_o
);
  logic [LZ_W-1:0]  lz;
  logic [MAN_W-1:0] man;
  logic [EXP_W-1:0] exp_r;

  always_comb begin
    lz = LZ_W'(Q_W);
    for (int i = 0; i < Q_W; i++) begin
      if (quot_i[i]) lz = LZ_W'(Q_W - 1 - i);
    end
  end

  always_comb begin
    man    = MAN_W'((quot_i << lz) >> (Q_W - MAN_W));
    exp_r  = EXP_W'(exp_base_i - EB_W'(lz) - EB_W'(1));
    word_o = (zero_i || quot_i == '0) ? '0 : {sign_i, exp_r, man[MAN_W-2:0]};
  end

  // R3
  always_comb begin
    if (quot_i != '0) norm_lead_chk: assert (man[MAN_W-1]);
  end
endmodule

// File: rtl/fpdiv_nr.sv
`timescale 1ns/1ps
module fpdiv_nr #(
  parameter int EXP_W    = 8,
  parameter int MAN_W    = 24,
  parameter int Q_W      = 32,
  parameter int PRESHIFT = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     sign_a_i,
  input  logic [EXP_W-1:0]         exp_a_i,
  input  logic [MAN_W-1:0]         man_a_i,
  input  logic                     sign_b_i,
  input  logic [EXP_W-1:0]         exp_b_i,
  input  logic [MAN_W-1:0]         man_b_i,
  output logic                     done_o,
  output logic [EXP_W+MAN_W-1:0]   result_o
);
  import fpdiv_nr_pkg::*;

  localparam int EB_W   = EXP_W + 2;
  localparam int WORD_W = EXP_W + MAN_W;

  // quotient must keep MAN_W bits below its leading one
  if (PRESHIFT > Q_W - MAN_W || Q_W < MAN_W + 3) begin : g_bad_cfg
    $error("fpdiv_nr: PRESHIFT/Q_W leave too few quotient bits");
  end

  div_state_e        state_q;
  logic              accept, last, sign_c, sign_q, zero_q;
  logic [EB_W-1:0]   exp_base_c, exp_base_q;
  logic [Q_W-1:0]    quot;
  logic [WORD_W-1:0] word;

  assign accept = start_i && (state_q == ST_IDLE);

  fpdiv_nr_se #(.EXP_W(EXP_W), .PRESHIFT(PRESHIFT)) u_se (
    .sign_a_i  (sign_a_i),
    .sign_b_i  (sign_b_i),
    .exp_a_i   (exp_a_i),
    .exp_b_i   (exp_b_i),
    .sign_o    (sign_c),
    .exp_base_o(exp_base_c)
  );

  fpdiv_nr_core #(.MAN_W(MAN_W), .Q_W(Q_W), .PRESHIFT(PRESHIFT)) u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .man_a_i(man_a_i),
    .man_b_i(man_b_i),
    .last_o (last),
    .quot_o (quot)
  );

  fpdiv_nr_norm #(.MAN_W(MAN_W), .EXP_W(EXP_W), .Q_W(Q_W)) u_norm (
    .sign_i    (sign_q),
    .exp_base_i(exp_base_q),
    .zero_i    (zero_q),
    .quot_i    (quot),
    .word_o    (word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      sign_q     <= 1'b0;
      exp_base_q <= '0;
      zero_q     <= 1'b0;
      done_o     <= 1'b0;
      result_o   <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          sign_q     <= sign_c;
          exp_base_q <= exp_base_c;
          zero_q     <= (man_b_i == '0);
          state_q    <= ST_RUN;
        end
        ST_RUN:  if (last) state_q <= ST_NORM;
        ST_NORM: begin
          result_o <= word;
          done_o   <= 1'b1;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R5
  done_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(state_q == ST_NORM));
  // R6
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));
  // R7
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && state_q != ST_IDLE) |=>
      ($stable(sign_q) && $stable(exp_base_q) && $stable(zero_q)));
  // R8
  zero_div_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && zero_q) |-> (result_o == '0));
endmodule

// File: tb/fpdiv_nr_tb.sv
`timescale 1ns/1ps
module fpdiv_nr_tb;
  localparam int LAT = 33;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        sa = 1'b0, sb = 1'b0;
  logic [7:0]  ea = '0, eb = '0;
  logic [23:0] ma = '0, mb = '0;
  logic        done;
  logic [31:0] res;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] seed = 32'h1234_5677;

  always #2 clk = ~clk;

  fpdiv_nr u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .sign_a_i(sa), .exp_a_i(ea), .man_a_i(ma),
    .sign_b_i(sb), .exp_b_i(eb), .man_b_i(mb),
    .done_o(done), .result_o(res)
  );

  function automatic logic [31:0] model(input logic s1, input logic [7:0] e1,
                                        input logic [23:0] m1, input logic s2,
                                        input logic [7:0] e2, input logic [23:0] m2);
    logic [63:0] q;
    logic [7:0]  e;
    logic [23:0] m;
    if (m1 == 0 || m2 == 0) return 32'h0;
    q = (64'(m1) << 24) / 64'(m2);
    if (q[24]) begin m = q[24:1]; e = e1 - e2 + 8'd127; end
    else       begin m = q[23:0]; e = e1 - e2 + 8'd126; end
    return {s1 ^ s2, e, m[22:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drive fields, pulse start, check latency, value, pulse width and hold
  task automatic run_fields(input string req, input logic s1, input logic [7:0] e1,
                            input logic [23:0] m1, input logic s2, input logic [7:0] e2,
                            input logic [23:0] m2, input logic [31:0] exp);
    int early = 0;
    @(negedge clk);
    sa = s1; ea = e1; ma = m1; sb = s2; eb = e2; mb = m2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 1; i < LAT; i++) begin
      @(negedge clk);
      if (done) early++;
    end
    check("R5 early done", 32'(early), 32'd0);
    @(negedge clk);
    check("R5 done at latency", 32'(done), 32'd1);
    check(req, res, exp);
    @(negedge clk);
    check("R5 one-cycle done", 32'(done), 32'd0);
    check("R6 result held", res, exp);
  endtask

  task automatic run_words(input string req, input logic [31:0] a, input logic [31:0] b,
                           input logic [31:0] exp);
    run_fields(req, a[31], a[30:23], {1'b1, a[22:0]}, b[31], b[30:23], {1'b1, b[22:0]}, exp);
  endtask

  task automatic t_reset();
    #1;
    check("R10 reset done", 32'(done), 32'd0);
    check("R10 reset result", res, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_directed();
    run_words("R4 sample vector", 32'h19FF0000, 32'h18010000, 32'h417D05F4);
    run_words("R2 equal mantissas", 32'h3F800000, 32'h3F800000, 32'h3F800000);
    run_words("R2 half", 32'h3F800000, 32'h40000000, 32'h3F000000);
    run_words("R3 three halves", 32'h40400000, 32'h40000000, 32'h3FC00000);
    run_words("R1 negative dividend", 32'hC0C00000, 32'h40400000, 32'hC0000000);
    run_words("R1 both negative", 32'hC0C00000, 32'hC0400000, 32'h40000000);
    run_words("R3 one third", 32'h3F800000, 32'h40400000, 32'h3EAAAAAA);
    run_words("R3 max ratio", 32'h3FFFFFFF, 32'h3F800000, 32'h3FFFFFFF);
    run_words("R3 min ratio", 32'h3F800000, 32'h3FFFFFFF,
              model(1'b0, 8'h7F, 24'h800000, 1'b0, 8'h7F, 24'hFFFFFF));
  endtask

  task automatic t_zero();
    run_fields("R8 zero divisor", 1'b1, 8'h90, 24'hC00000, 1'b0, 8'h10, 24'h0, 32'h0);
    run_fields("R9 zero dividend", 1'b0, 8'h00, 24'h0, 1'b1, 8'h85, 24'hA00000, 32'h0);
  endtask

  task automatic t_busy_start();
    logic [31:0] exp;
    int early = 0;
    int extra = 0;
    exp = model(1'b0, 8'h82, 24'hE00000, 1'b0, 8'h80, 24'hC00000);
    @(negedge clk);
    sa = 1'b0; ea = 8'h82; ma = 24'hE00000; sb = 1'b0; eb = 8'h80; mb = 24'hC00000;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 1; i < LAT; i++) begin
      @(negedge clk);
      if (i == 10) begin
        sa = 1'b1; ea = 8'h20; ma = 24'hFFFFFF; sb = 1'b0; eb = 8'h70; mb = 24'h0;
        start = 1'b1;
      end else start = 1'b0;
      if (done) early++;
    end
    check("R7 no early done", 32'(early), 32'd0);
    @(negedge clk);
    check("R7 done on schedule", 32'(done), 32'd1);
    check("R7 first operands kept", res, exp);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (done) extra++;
    end
    check("R7 no second done", 32'(extra), 32'd0);
    check("R6 result held idle", res, exp);
  endtask

  task automatic t_random(input int n);
    for (int k = 0; k < n; k++) begin
      logic [31:0] a, b;
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      a = seed;
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      b = seed;
      run_words("R3 random", a, b,
                model(a[31], a[30:23], {1'b1, a[22:0]}, b[31], b[30:23], {1'b1, b[22:0]}));
    end
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_directed();
    t_zero();
    t_busy_start();
    t_random(40);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule